// File: doc/BRIEF.md
# Bit-Serial HDLC Frame Receiver with Two-Byte Address Filter

This block receives one HDLC channel one bit at a time. Each cycle in which `bit_en` is high carries one line bit on `bit_in`. The receiver finds frame edges from the flag pattern and drops the zeros the sender inserted for transparency. It assembles the body into octets, least significant bit first, and runs a CRC-16 check over every octet of the frame.

The first two octets are address octets. Each is compared against a configured value, and any bit whose mask bit is set is left out of the compare. An octet of all ones counts as a broadcast match. A frame that fails the filter produces no output at all.

The octets of an accepted frame go out one per beat on `out_data`. The two FCS octets are not sent. `out_sof` marks the first octet and `out_eof` marks the closing beat. On that beat `out_stat` reports a CRC error, an abort or a frame that was too short. A frame that ends badly before it can deliver data closes with an `out_eof` beat that has `out_valid` low.

Top module: `hdlc_addr_rx`

## Requirements
- R1: After reset all outputs are low and the receiver is in hunt. Line bits that arrive before the first flag produce no beats, even when a flag follows them.
- R2: The flag 01111110 opens and closes a frame. Octets are assembled LSB first. For a frame of four or more octets, every octet except the last two (the FCS) is delivered in order, one per `out_valid` beat, and `out_sof` is set on the first one.
- R3: The last data octet's beat carries `out_eof`. The CRC register starts at 0xFFFF and uses the reflected CCITT polynomial (0x8408, LSB first) over all octets including the FCS. `out_stat` bit 0 is set when the final value differs from 0xF0B8.
- R4: A zero that follows five consecutive ones inside a frame is removed, so octet values such as 0xFF, 0x7E and 0x1F come out unchanged.
- R5: Two flags that share one zero, repeated flags, and runs of idle ones between frames are all legal fill. None of them produces a beat, and the next frame is received correctly.
- R6: Seven ones inside a frame that has at least one whole octet end it. The result is one `out_eof` beat with `out_valid` low and `out_stat` bit 1 set. The receiver then ignores the line until the next flag.
- R7: A frame of one to three octets between flags produces no data beats. It produces one `out_eof` beat with `out_valid` low and `out_stat` bit 2 set.
- R8: With `addr_en` high, octet 0 must match `addr_cmp0` and octet 1 must match `addr_cmp1`. Bits set in `addr_mask0` or `addr_mask1` are ignored in the compare.
- R9: With `addr_en` high, an address octet equal to 0xFF matches in its own position, whatever the compare value is.
- R10: A frame that fails the address filter produces no beats, not even `out_eof`. With `addr_en` low, every frame passes.
- R11: Each beat lasts one cycle and comes in the cycle after a `bit_en` cycle. `out_stat` is non-zero only on an `out_eof` beat, and it has at most one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Line bit strobe |
| bit_in | input | 1 | Line bit, valid when bit_en is high |
| addr_en | input | 1 | Enables the address filter |
| addr_cmp0 | input | 8 | Compare value for octet 0 |
| addr_mask0 | input | 8 | Ignore mask for octet 0 (1 = ignore) |
| addr_cmp1 | input | 8 | Compare value for octet 1 |
| addr_mask1 | input | 8 | Ignore mask for octet 1 (1 = ignore) |
| out_valid | output | 1 | out_data holds a frame octet |
| out_data | output | 8 | Delivered octet |
| out_sof | output | 1 | First octet of a frame |
| out_eof | output | 1 | Closing beat of a frame |
| out_stat | output | 3 | {short, abort, crc error}, valid with out_eof |

## Verification
The hardest cases to reach are line patterns that sit right at the decision points of the bit-level state. These are a zero shared by two flags, a run of seven ones after some whole octets, and stray octets that arrive during hunt and would look like a short frame if hunt were not honoured. The bench does not rely on octet-level stimulus for these. It writes raw line bits itself, with a transmitter that inserts zeros when it should and can be bypassed on purpose. This lets it place a shared-zero flag, an unstuffed run of ones or a burst of idle ones at exact bit positions, and then send a normally framed packet to show the receiver has recovered.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
   localparam int unsigned OCTET_W = 8;
   typedef logic [OCTET_W-1:0] octet_t;

   // closing status: bit 2 short, bit 1 abort, bit 0 CRC error
   typedef struct packed {
      logic short_frm;
      logic aborted;
      logic crc_bad;
   } rx_stat_t;
endpackage

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
   import hdlc_rx_pkg::*;
#(
   parameter int unsigned STUFF_RUN = 5
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   bit_en,
   input  logic   bit_in,
   output logic   flag_evt,
   output logic   abort_evt,
   output logic   byte_evt,
   output octet_t byte_val
);
   localparam int unsigned ONES_MAX = STUFF_RUN + 2;
   localparam int unsigned ONES_W   = $clog2(ONES_MAX + 1);
   localparam int unsigned BCNT_W   = $clog2(OCTET_W);

   if (STUFF_RUN < 2) begin : g_bad_run
      $error("STUFF_RUN must be at least 2");
   end

   logic [ONES_W-1:0] ones_q;
   logic [BCNT_W-1:0] bcnt_q;
   octet_t            shift_q;
   logic              hunt_q;
   logic              data_bit;

   always_comb begin
      flag_evt  = bit_en & ~bit_in & (ones_q == ONES_W'(STUFF_RUN + 1));
      abort_evt = bit_en &  bit_in & (ones_q == ONES_W'(STUFF_RUN + 1)) & ~hunt_q;
      data_bit  = bit_en & ~hunt_q & (ones_q < ONES_W'(STUFF_RUN));
      byte_evt  = data_bit & (bcnt_q == BCNT_W'(OCTET_W - 1));
      byte_val  = {bit_in, shift_q[OCTET_W-1:1]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ones_q  <= '0;
         bcnt_q  <= '0;
         shift_q <= '0;
         hunt_q  <= 1'b1;
      end else if (bit_en) begin
         if (!bit_in)
            ones_q <= '0;
         else if (ones_q != ONES_W'(ONES_MAX))
            ones_q <= ones_q + 1'b1;

         if (flag_evt) begin
            hunt_q <= 1'b0;
            bcnt_q <= '0;
         end else if (abort_evt) begin
            hunt_q <= 1'b1;
            bcnt_q <= '0;
         end else if (data_bit) begin
            shift_q <= byte_val;
            bcnt_q  <= bcnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/hdlc_rx_crc.sv
module hdlc_rx_crc
   import hdlc_rx_pkg::*;
#(
   parameter int unsigned   CRC_W    = 16,
   parameter logic [CRC_W-1:0] CRC_POLY = 16'h8408,
   parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             upd,
   input  octet_t           din,
   output logic [CRC_W-1:0] crc_q
);
   if (CRC_W < OCTET_W) begin : g_bad_w
      $error("CRC_W must not be narrower than an octet");
   end

   logic [CRC_W-1:0] stage [0:OCTET_W];
   assign stage[0] = crc_q;

   for (genvar i = 0; i < OCTET_W; i++) begin : g_step
      assign stage[i+1] = (stage[i][0] ^ din[i]) ? ((stage[i] >> 1) ^ CRC_POLY)
                                                 :  (stage[i] >> 1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr)
         crc_q <= CRC_INIT;
      else if (upd)
         crc_q <= stage[OCTET_W];
   end
endmodule

// File: rtl/hdlc_rx_addr_match.sv
module hdlc_rx_addr_match
   import hdlc_rx_pkg::*;
#(
   parameter int unsigned NPOS = 2
) (
   input  logic [NPOS*OCTET_W-1:0] rx_vec,
   input  logic [NPOS*OCTET_W-1:0] cmp_vec,
   input  logic [NPOS*OCTET_W-1:0] mask_vec,
   output logic                    hit
);
   if (NPOS < 1) begin : g_bad_n
      $error("NPOS must be at least 1");
   end

   logic [NPOS-1:0] pos_hit;

   for (genvar p = 0; p < NPOS; p++) begin : g_pos
      octet_t rx_b, cmp_b, msk_b;
      assign rx_b  = rx_vec  [p*OCTET_W +: OCTET_W];
      assign cmp_b = cmp_vec [p*OCTET_W +: OCTET_W];
      assign msk_b = mask_vec[p*OCTET_W +: OCTET_W];
      assign pos_hit[p] = (&rx_b) | (((rx_b ^ cmp_b) & ~msk_b) == '0);
   end

   assign hit = &pos_hit;
endmodule

// File: rtl/hdlc_addr_rx.sv
module hdlc_addr_rx
   import hdlc_rx_pkg::*;
#(
   parameter int unsigned  STUFF_RUN = 5,
   parameter logic [15:0]  CRC_POLY  = 16'h8408,
   parameter logic [15:0]  CRC_INIT  = 16'hFFFF,
   parameter logic [15:0]  CRC_GOOD  = 16'hF0B8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_en,
   input  logic       bit_in,
   input  logic       addr_en,
   input  logic [7:0] addr_cmp0,
   input  logic [7:0] addr_mask0,
   input  logic [7:0] addr_cmp1,
   input  logic [7:0] addr_mask1,
   output logic       out_valid,
   output logic [7:0] out_data,
   output logic       out_sof,
   output logic       out_eof,
   output logic [2:0] out_stat
);
   localparam int unsigned ADDR_N  = 2;
   localparam int unsigned FCS_N   = 2;
   localparam int unsigned MIN_LEN = ADDR_N + FCS_N;
   localparam int unsigned QDEPTH  = FCS_N + 1;
   localparam int unsigned CNT_W   = $clog2(MIN_LEN + 1);

   if (CRC_POLY == 16'h0) begin : g_bad_poly
      $error("CRC_POLY must be non-zero");
   end

   logic   flag_evt, abort_evt, byte_evt;
   octet_t byte_val;
   logic [15:0] crc_q;
   logic   addr_hit;
   octet_t hold_q [QDEPTH];
   logic [CNT_W-1:0] cnt_q;
   logic   rej_q;
   logic   live;
   rx_stat_t stat_q;

   hdlc_rx_deframer #(.STUFF_RUN(STUFF_RUN)) i_deframer (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_en    (bit_en),
      .bit_in    (bit_in),
      .flag_evt  (flag_evt),
      .abort_evt (abort_evt),
      .byte_evt  (byte_evt),
      .byte_val  (byte_val)
   );

   hdlc_rx_crc #(.CRC_W(16), .CRC_POLY(CRC_POLY), .CRC_INIT(CRC_INIT)) i_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (flag_evt | abort_evt),
      .upd   (byte_evt),
      .din   (byte_val),
      .crc_q (crc_q)
   );

   hdlc_rx_addr_match #(.NPOS(ADDR_N)) i_addr (
      .rx_vec   ({byte_val, hold_q[QDEPTH-1]}),
      .cmp_vec  ({addr_cmp1, addr_cmp0}),
      .mask_vec ({addr_mask1, addr_mask0}),
      .hit      (addr_hit)
   );

   assign live     = (cnt_q != '0) & ~rej_q;
   assign out_stat = stat_q;

   // octet hold line: [0] oldest, [QDEPTH-1] newest
   for (genvar k = 0; k < QDEPTH; k++) begin : g_hold
      always_ff @(posedge clk) begin
         if (!rst_n)
            hold_q[k] <= '0;
         else if (byte_evt)
            hold_q[k] <= (k == QDEPTH-1) ? byte_val : hold_q[(k+1) % QDEPTH];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         rej_q     <= 1'b0;
         out_valid <= 1'b0;
         out_data  <= '0;
         out_sof   <= 1'b0;
         out_eof   <= 1'b0;
         stat_q    <= '0;
      end else begin
         out_valid <= 1'b0;
         out_sof   <= 1'b0;
         out_eof   <= 1'b0;
         stat_q    <= '0;
         if (flag_evt) begin
            if (live) begin
               out_eof <= 1'b1;
               if (cnt_q == CNT_W'(MIN_LEN)) begin
                  out_valid      <= 1'b1;
                  out_data       <= hold_q[0];
                  stat_q.crc_bad <= (crc_q != CRC_GOOD);
               end else begin
                  stat_q.short_frm <= 1'b1;
               end
            end
            cnt_q <= '0;
            rej_q <= 1'b0;
         end else if (abort_evt) begin
            if (live) begin
               out_eof        <= 1'b1;
               stat_q.aborted <= 1'b1;
            end
            cnt_q <= '0;
            rej_q <= 1'b0;
         end else if (byte_evt) begin
            if (cnt_q != CNT_W'(MIN_LEN))
               cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(ADDR_N - 1))
               rej_q <= addr_en & ~addr_hit;
            if ((cnt_q >= CNT_W'(MIN_LEN - 1)) && !rej_q) begin
               out_valid <= 1'b1;
               out_data  <= hold_q[0];
               out_sof   <= (cnt_q == CNT_W'(MIN_LEN - 1));
            end
         end
      end
   end
endmodule

// File: rtl/hdlc_addr_rx_chk.sv
module hdlc_addr_rx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bit_en,
   input logic       out_valid,
   input logic       out_sof,
   input logic       out_eof,
   input logic [2:0] out_stat
);
   a_r2_sof_has_octet: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof |-> out_valid);

   a_r11_beat_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid || out_eof) |-> $past(bit_en));

   a_r11_stat_only_on_eof: assert property (@(posedge clk) disable iff (!rst_n)
      (out_stat != 3'b000) |-> out_eof);

   a_r11_one_stat_bit: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(out_stat));

   a_r11_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   a_r11_eof_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      out_eof |=> !out_eof);

   a_r6_abort_no_octet: assert property (@(posedge clk) disable iff (!rst_n)
      out_stat[1] |-> !out_valid);

   a_r7_short_no_octet: assert property (@(posedge clk) disable iff (!rst_n)
      out_stat[2] |-> !out_valid);
endmodule

bind hdlc_addr_rx hdlc_addr_rx_chk i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bit_en    (bit_en),
   .out_valid (out_valid),
   .out_sof   (out_sof),
   .out_eof   (out_eof),
   .out_stat  (out_stat)
);

// File: tb/test_hdlc_addr_rx.sv
module test_hdlc_addr_rx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0;
   logic       bit_in = 1'b1;
   logic       addr_en = 1'b0;
   logic [7:0] addr_cmp0 = '0, addr_mask0 = '0, addr_cmp1 = '0, addr_mask1 = '0;
   logic       out_valid, out_sof, out_eof;
   logic [7:0] out_data;
   logic [2:0] out_stat;

   always #5 clk = ~clk;

   hdlc_addr_rx i_hdlc_addr_rx (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
      .addr_en(addr_en), .addr_cmp0(addr_cmp0), .addr_mask0(addr_mask0),
      .addr_cmp1(addr_cmp1), .addr_mask1(addr_mask1),
      .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
      .out_eof(out_eof), .out_stat(out_stat)
   );

   int checks = 0;
   int errors = 0;

   logic [7:0] cap_d [0:63];
   logic       cap_s [0:63];
   logic       cap_e [0:63];
   int         cap_n = 0;
   int         eof_n = 0;
   logic [2:0] eof_stat = '0;
   logic       eof_byte = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (out_eof) begin
            eof_n++;
            eof_stat = out_stat;
            eof_byte = out_valid;
         end
         if (out_valid && cap_n < 64) begin
            cap_d[cap_n] = out_data;
            cap_s[cap_n] = out_sof;
            cap_e[cap_n] = out_eof;
            cap_n++;
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic clr_cap();
      cap_n = 0; eof_n = 0; eof_stat = '0; eof_byte = 1'b0;
   endtask

   function automatic logic [15:0] crc_octet(input logic [15:0] c, input logic [7:0] d);
      logic [15:0] r;
      r = c;
      for (int i = 0; i < 8; i++)
         r = (r[0] ^ d[i]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
      return r;
   endfunction

   logic [7:0] fb [0:15];
   int tx_ones = 0;

   task automatic tx_bit(input logic b);
      @(negedge clk);
      bit_in = b;
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
   endtask

   task automatic tx_dbit(input logic b);
      tx_bit(b);
      if (b) begin
         tx_ones++;
         if (tx_ones == 5) begin
            tx_bit(1'b0);
            tx_ones = 0;
         end
      end else begin
         tx_ones = 0;
      end
   endtask

   task automatic tx_octet(input logic [7:0] b);
      for (int i = 0; i < 8; i++) tx_dbit(b[i]);
   endtask

   task automatic tx_flag();
      tx_bit(1'b0);
      for (int i = 0; i < 6; i++) tx_bit(1'b1);
      tx_bit(1'b0);
      tx_ones = 0;
   endtask

   task automatic tx_raw_ones(input int n);
      for (int i = 0; i < n; i++) tx_bit(1'b1);
      tx_ones = 0;
   endtask

   task automatic send_body(input int n, input bit with_fcs, input bit corrupt);
      logic [15:0] c;
      c = 16'hFFFF;
      for (int i = 0; i < n; i++) begin
         tx_octet(fb[i]);
         c = crc_octet(c, fb[i]);
      end
      if (with_fcs) begin
         c = ~c;
         if (corrupt) c = c ^ 16'h0100;
         tx_octet(c[7:0]);
         tx_octet(c[15:8]);
      end
      tx_flag();
      repeat (4) @(negedge clk);
   endtask

   task automatic send_frame(input int n, input bit with_fcs, input bit corrupt);
      tx_flag();
      send_body(n, with_fcs, corrupt);
   endtask

   // beats must equal octets: a beat held two cycles would be counted twice (R11)
   task automatic expect_frame(input string req, input int n, input logic [2:0] st);
      check(cap_n == n, req, cap_n, n);
      for (int i = 0; i < n && i < cap_n; i++) begin
         check(cap_d[i] == fb[i], req, cap_d[i], fb[i]);
         check(cap_s[i] == (i == 0), req, cap_s[i], (i == 0));
         check(cap_e[i] == (i == n-1), req, cap_e[i], (i == n-1));
      end
      check(eof_n == 1, req, eof_n, 1);
      check(eof_stat == st, req, eof_stat, st);
   endtask

   task automatic t_reset();
      check({out_valid, out_sof, out_eof, out_stat} == '0, "R1 reset outputs",
            {out_valid, out_sof, out_eof, out_stat}, 0);
      clr_cap();
      tx_octet(8'h12); tx_octet(8'h34); tx_octet(8'h56);
      tx_flag();
      repeat (4) @(negedge clk);
      check(cap_n == 0, "R1 hunt before first flag", cap_n, 0);
      check(eof_n == 0, "R1 hunt before first flag", eof_n, 0);
   endtask

   task automatic t_basic();
      clr_cap();
      fb[0]=8'h01; fb[1]=8'h03; fb[2]=8'hA5; fb[3]=8'h5A; fb[4]=8'hC3; fb[5]=8'h3C;
      send_frame(6, 1, 0);
      expect_frame("R2 R3 good frame", 6, 3'b000);
      check(eof_byte == 1'b1, "R3 eof on last octet", eof_byte, 1);
   endtask

   task automatic t_stuff();
      clr_cap();
      fb[0]=8'hFF; fb[1]=8'h7E; fb[2]=8'h1F; fb[3]=8'hF8; fb[4]=8'hFF; fb[5]=8'h3E;
      send_frame(6, 1, 0);
      expect_frame("R4 zero removal", 6, 3'b000);
   endtask

   task automatic t_crc();
      clr_cap();
      fb[0]=8'h10; fb[1]=8'h20; fb[2]=8'h30; fb[3]=8'h40;
      send_frame(4, 1, 1);
      expect_frame("R3 crc error flag", 4, 3'b001);
   endtask

   task automatic t_short();
      clr_cap();
      fb[0]=8'h77;
      send_frame(1, 1, 0);
      check(cap_n == 0, "R7 short no octets", cap_n, 0);
      check(eof_n == 1, "R7 short eof", eof_n, 1);
      check(eof_stat == 3'b100, "R7 short status", eof_stat, 3'b100);
      check(eof_byte == 1'b0, "R7 eof without octet", eof_byte, 0);
      clr_cap();
      fb[0]=8'h01; fb[1]=8'h02;
      send_frame(2, 0, 0);
      check(eof_n == 1 && eof_stat == 3'b100, "R7 two-octet frame", eof_stat, 3'b100);
   endtask

   task automatic t_abort();
      clr_cap();
      fb[0]=8'h01; fb[1]=8'h02; fb[2]=8'h03; fb[3]=8'h04; fb[4]=8'h05;
      tx_flag();
      for (int i = 0; i < 5; i++) tx_octet(fb[i]);
      tx_raw_ones(9);
      repeat (4) @(negedge clk);
      check(cap_n == 2, "R6 octets before abort", cap_n, 2);
      check(eof_n == 1, "R6 abort eof", eof_n, 1);
      check(eof_stat == 3'b010, "R6 abort status", eof_stat, 3'b010);
      check(eof_byte == 1'b0, "R6 abort eof without octet", eof_byte, 0);
      clr_cap();
      tx_octet(8'h11); tx_octet(8'h22);
      fb[0]=8'hAA; fb[1]=8'hBB; fb[2]=8'hCC; fb[3]=8'hDD;
      send_frame(4, 1, 0);
      expect_frame("R6 recovery after hunt", 4, 3'b000);
   endtask

   task automatic t_fill();
      clr_cap();
      tx_flag(); tx_flag(); tx_raw_ones(24); tx_flag(); tx_flag();
      repeat (4) @(negedge clk);
      check(cap_n == 0 && eof_n == 0, "R5 fill makes no beats", eof_n, 0);
      clr_cap();
      fb[0]=8'h5A; fb[1]=8'h0F; fb[2]=8'hF0; fb[3]=8'h81;
      tx_raw_ones(20);
      send_frame(4, 1, 0);
      expect_frame("R5 frame after idle ones", 4, 3'b000);
      clr_cap();
      tx_flag();
      for (int i = 0; i < 6; i++) tx_bit(1'b1);
      tx_bit(1'b0);
      tx_ones = 0;
      fb[0]=8'h42; fb[1]=8'h24; fb[2]=8'h99; fb[3]=8'h66; fb[4]=8'hE7;
      send_body(5, 1, 0);
      expect_frame("R5 shared-zero flags", 5, 3'b000);
   endtask

   task automatic t_addr();
      addr_en = 1'b1; addr_cmp0 = 8'h30; addr_cmp1 = 8'h55;
      addr_mask0 = 8'h00; addr_mask1 = 8'h00;
      clr_cap();
      fb[0]=8'h30; fb[1]=8'h55; fb[2]=8'h03; fb[3]=8'hA5;
      send_frame(4, 1, 0);
      expect_frame("R8 exact address", 4, 3'b000);
      clr_cap();
      addr_mask0 = 8'h0C;
      fb[0]=8'h3C;
      send_frame(4, 1, 0);
      expect_frame("R8 masked address", 4, 3'b000);
      addr_mask0 = 8'h00;
   endtask

   task automatic t_bcast();
      addr_en = 1'b1; addr_cmp0 = 8'h31; addr_cmp1 = 8'h55;
      clr_cap();
      fb[0]=8'hFF; fb[1]=8'h55; fb[2]=8'h13; fb[3]=8'h37;
      send_frame(4, 1, 0);
      expect_frame("R9 broadcast octet 0", 4, 3'b000);
      addr_cmp0 = 8'h30; addr_cmp1 = 8'h66;
      clr_cap();
      fb[0]=8'h30; fb[1]=8'hFF;
      send_frame(4, 1, 0);
      expect_frame("R9 broadcast octet 1", 4, 3'b000);
   endtask

   task automatic t_reject();
      addr_en = 1'b1; addr_cmp0 = 8'h30; addr_cmp1 = 8'h55;
      clr_cap();
      fb[0]=8'h30; fb[1]=8'h56; fb[2]=8'h01; fb[3]=8'h02; fb[4]=8'h03;
      send_frame(5, 1, 0);
      check(cap_n == 0, "R10 rejected no octets", cap_n, 0);
      check(eof_n == 0, "R10 rejected no eof", eof_n, 0);
      addr_en = 1'b0;
      clr_cap();
      send_frame(5, 1, 0);
      expect_frame("R10 filter off passes", 5, 3'b000);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_stuff();
      t_crc();
      t_short();
      t_abort();
      t_fill();
      t_addr();
      t_bcast();
      t_reject();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule